// File: doc/BRIEF.md
# Two-Class Interrupt Controller Register Bank

This block gathers forty level-sensitive peripheral request lines and turns them into two processor interrupt lines, a normal one and a fast one. Every source carries an enable bit and a class bit; the class bit routes an enabled, pending source to the fast line when set and to the normal line when clear. Sources 0 to 31 live in a low register bank and sources 32 to 39 live in bits 0 to 7 of a high register bank.

A plain 32-bit register bus reads and writes the enable, class, control and per-source priority registers, and reads three views of the request state. These are everything raw, only the enabled normal-class requests, and only the enabled fast-class requests. A control bit selects whether, while the core reports it is idle, any raw request or only an enabled request raises the wake output. The priority registers are storage only. A separate resolver reads them.

Top module: `intc_two_class`

## Requirements
- R1: The raw request bit of each source copies its pin at every clock edge, with no latching; a pin that falls clears its bit at the next edge.
- R2: Source k below 32 is bit k of each low-bank register. Source k from 32 up is bit k-32 of each high-bank register. High-bank bits 8 to 31 read as zero and ignore writes.
- R3: The word offsets are as follows. Low bank: 0x10 raw, 0x00 normal view, 0x0C fast view, 0x04 enable, 0x08 class. High bank: 0xAC raw, 0x9C normal view, 0xA8 fast view, 0xA0 enable, 0xA4 class. 0x14 is control. Priority register i sits at 0x1C+4i for i<32 and at 0xB0+4(i-32) for i>=32.
- R4: The normal view reads raw & enable & ~class. The fast view reads raw & enable & class. The raw register reads the request bits with no enable applied.
- R5: fiq_o is high exactly when some source in either bank is raw, enabled and has class 1.
- R6: irq_o is high exactly when some source in either bank is raw, enabled and has class 0.
- R7: Writing control bit 0 as 1 selects wake-on-enabled-only and the control register then reads 1. Writing it as 0 selects wake-on-any-request and it reads 0. Reset selects wake-on-any-request.
- R8: wake_o is high exactly when idle_i is high and raw & (enable | all-ones-when-wake-on-any) is nonzero in either bank.
- R9: A priority register write stores only bit 31 (valid) and bits 5:0 (source number); all other bits read back as zero.
- R10: After reset, all raw, enable and class bits, all priority registers, and all three outputs are zero.
- R11: Writes to the raw and view registers and to unmapped or unaligned offsets change nothing. Reads of unmapped offsets return zero.
- R12: irq_o, fiq_o and wake_o reflect a pin change or a register write at the first clock edge that samples it. bus_rdata shows, after an edge, the register addressed at that edge as it stood before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 40 | Peripheral request levels, one per source |
| idle_i | input | 1 | Core idle indication |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the offset sampled at the last edge |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Wake request to an idle core |

## Verification
The bench places enabled requests of both classes in both banks at once, so that a design swapping the class sense or dropping the high bank shows wrong bits in the normal and fast views and on the two lines. It drops a pin after it was seen, to catch a design that latches requests instead of following the level. It moves between the two wake modes with a masked request present, where a design with the inverted control sense or a wake output that ignores idle_i raises or drops wake_o at the wrong time. It also writes all-ones into priority, read-only and unmapped offsets, to catch stored reserved bits, writable pending bits and an offset decode that aliases.

// File: rtl/intc_pkg.sv
// Package: shared offsets, priority entry type and offset helpers for the
// two-class interrupt controller. Assumes a byte-addressed 32-bit register bus.
package intc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int LO_W   = 32;
    localparam int SID_W  = 6;

    localparam logic [ADDR_W-1:0] A_NRM_LO  = 8'h00;
    localparam logic [ADDR_W-1:0] A_ENA_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] A_CLS_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] A_FST_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_RAW_LO  = 8'h10;
    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h14;
    localparam logic [ADDR_W-1:0] A_PRI_LO  = 8'h1C;
    localparam logic [ADDR_W-1:0] A_NRM_HI  = 8'h9C;
    localparam logic [ADDR_W-1:0] A_ENA_HI  = 8'hA0;
    localparam logic [ADDR_W-1:0] A_CLS_HI  = 8'hA4;
    localparam logic [ADDR_W-1:0] A_FST_HI  = 8'hA8;
    localparam logic [ADDR_W-1:0] A_RAW_HI  = 8'hAC;
    localparam logic [ADDR_W-1:0] A_PRI_HI  = 8'hB0;

    typedef struct packed {
        logic             valid;
        logic [SID_W-1:0] sid;
    } prio_t;

    // Byte offset of priority entry idx.
    function automatic logic [ADDR_W-1:0] prio_off(input int idx);
        if (idx < LO_W)
            return ADDR_W'(int'(A_PRI_LO) + 4 * idx);
        else
            return ADDR_W'(int'(A_PRI_HI) + 4 * (idx - LO_W));
    endfunction
endpackage

// File: rtl/intc_src_latch.sv
// Module: raw request register. Samples each source pin every cycle (level
// following, no latching). Assumes pins are already synchronous to clk.
module intc_src_latch #(
    parameter int N_SRC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] pend_d,
    output logic [N_SRC-1:0] pend_q
);
    // Next raw state is simply the current pin levels.
    assign pend_d = src_i;

    // Capture pin levels each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R1: raw bits track the pins sampled one edge earlier
    a_r1_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(src_i));
endmodule

// File: rtl/intc_cfg_regs.sv
// Module: writable configuration: enable, class, wake mode and priority
// entries. Exposes both next-state and registered values so that outputs can
// reflect a write one edge after it. Assumes 33..64 sources.
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int N_SRC = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [N_SRC-1:0]    ena_d,
    output logic [N_SRC-1:0]    ena_q,
    output logic [N_SRC-1:0]    cls_d,
    output logic [N_SRC-1:0]    cls_q,
    output logic                any_wake_d,
    output logic                any_wake_q,
    output prio_t               prio_q [N_SRC]
);
    localparam int HI_W = N_SRC - LO_W;

    // Next-state of enable, class and wake mode from the bus write.
    always_comb begin
        ena_d      = ena_q;
        cls_d      = cls_q;
        any_wake_d = any_wake_q;
        if (bus_wr) begin
            case (bus_addr)
                A_ENA_LO: ena_d[LO_W-1:0]     = bus_wdata[LO_W-1:0];
                A_ENA_HI: ena_d[N_SRC-1:LO_W] = bus_wdata[HI_W-1:0];
                A_CLS_LO: cls_d[LO_W-1:0]     = bus_wdata[LO_W-1:0];
                A_CLS_HI: cls_d[N_SRC-1:LO_W] = bus_wdata[HI_W-1:0];
                A_CTRL:   any_wake_d          = ~bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Hold enable, class and wake mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q      <= '0;
            cls_q      <= '0;
            any_wake_q <= 1'b1;
        end else begin
            ena_q      <= ena_d;
            cls_q      <= cls_d;
            any_wake_q <= any_wake_d;
        end
    end

    // One priority entry per source, each with its own offset decode.
    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_prio
        localparam logic [ADDR_W-1:0] MY_OFF = prio_off(gi);
        // Store valid and source number on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[gi] <= '0;
            else if (bus_wr && bus_addr == MY_OFF)
                prio_q[gi] <= '{valid: bus_wdata[31], sid: bus_wdata[SID_W-1:0]};
        end
    end

    // R11: a write outside the enable offsets leaves the enable bits alone
    a_r11_ena_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_ENA_LO || bus_addr == A_ENA_HI))
        |=> $stable(ena_q));
endmodule

// File: rtl/intc_out_gen.sv
// Module: registered interrupt and wake lines. Works on next-state values so
// each line settles one edge after the pin change or write that moves it.
module intc_out_gen #(
    parameter int N_SRC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_d,
    input  logic [N_SRC-1:0] ena_d,
    input  logic [N_SRC-1:0] cls_d,
    input  logic             any_wake_d,
    input  logic             idle_i,
    output logic             irq_o,
    output logic             fiq_o,
    output logic             wake_o
);
    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] wake_src;

    // Enabled requests, and requests that may wake the core.
    always_comb begin
        live     = pend_d & ena_d;
        wake_src = pend_d & (ena_d | {N_SRC{any_wake_d}});
    end

    // Register the two interrupt lines and the wake request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            fiq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= |(live & ~cls_d);
            fiq_o  <= |(live &  cls_d);
            wake_o <= idle_i && (|wake_src);
        end
    end

    // R8: wake only follows an edge at which the core was idle
    a_r8_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(idle_i));
endmodule

// File: rtl/intc_rd_mux.sv
// Module: registered read port. Decodes the offset presented at an edge and
// returns the addressed register as held before that edge; unmapped is zero.
module intc_rd_mux
    import intc_pkg::*;
#(
    parameter int N_SRC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  pend_q,
    input  logic [N_SRC-1:0]  ena_q,
    input  logic [N_SRC-1:0]  cls_q,
    input  logic              any_wake_q,
    input  prio_t             prio_q [N_SRC],
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int HI_W = N_SRC - LO_W;
    localparam int PAD  = DATA_W - HI_W;

    logic [N_SRC-1:0]  nrm;
    logic [N_SRC-1:0]  fst;
    logic [DATA_W-1:0] rd_nxt;
    logic              is_prio;

    // Class-filtered views of enabled requests.
    always_comb begin
        nrm = pend_q & ena_q & ~cls_q;
        fst = pend_q & ena_q &  cls_q;
    end

    // Offset decode into the next read word.
    always_comb begin
        rd_nxt  = '0;
        is_prio = 1'b0;
        case (bus_addr)
            A_RAW_LO: rd_nxt = pend_q[LO_W-1:0];
            A_NRM_LO: rd_nxt = nrm[LO_W-1:0];
            A_FST_LO: rd_nxt = fst[LO_W-1:0];
            A_ENA_LO: rd_nxt = ena_q[LO_W-1:0];
            A_CLS_LO: rd_nxt = cls_q[LO_W-1:0];
            A_RAW_HI: rd_nxt = {{PAD{1'b0}}, pend_q[N_SRC-1:LO_W]};
            A_NRM_HI: rd_nxt = {{PAD{1'b0}}, nrm[N_SRC-1:LO_W]};
            A_FST_HI: rd_nxt = {{PAD{1'b0}}, fst[N_SRC-1:LO_W]};
            A_ENA_HI: rd_nxt = {{PAD{1'b0}}, ena_q[N_SRC-1:LO_W]};
            A_CLS_HI: rd_nxt = {{PAD{1'b0}}, cls_q[N_SRC-1:LO_W]};
            A_CTRL:   rd_nxt = {{(DATA_W-1){1'b0}}, ~any_wake_q};
            default: ;
        endcase
        for (int i = 0; i < N_SRC; i++) begin
            if (bus_addr == prio_off(i)) begin
                is_prio = 1'b1;
                rd_nxt  = {prio_q[i].valid, {(DATA_W-1-SID_W){1'b0}}, prio_q[i].sid};
            end
        end
    end

    // Register the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_nxt;
    end

    // R9: a priority read never shows reserved bits
    a_r9_prio_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_prio) |-> bus_rdata[30:SID_W] == '0);
endmodule

// File: rtl/intc_two_class.sv
// Module: top of the two-class interrupt controller. Joins the raw request
// register, configuration registers, output generator and read port.
// Assumes 33..64 sources split into a 32-bit low bank and a high bank.
module intc_two_class
    import intc_pkg::*;
#(
    parameter int N_SRC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              idle_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);
    logic [N_SRC-1:0] pend_d, pend_q;
    logic [N_SRC-1:0] ena_d, ena_q;
    logic [N_SRC-1:0] cls_d, cls_q;
    logic             any_wake_d, any_wake_q;
    prio_t            prio_q [N_SRC];

    intc_src_latch #(.N_SRC(N_SRC)) u_src (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .pend_d(pend_d), .pend_q(pend_q)
    );

    intc_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .ena_d(ena_d), .ena_q(ena_q),
        .cls_d(cls_d), .cls_q(cls_q), .any_wake_d(any_wake_d),
        .any_wake_q(any_wake_q), .prio_q(prio_q)
    );

    intc_out_gen #(.N_SRC(N_SRC)) u_out (
        .clk(clk), .rst_n(rst_n), .pend_d(pend_d), .ena_d(ena_d),
        .cls_d(cls_d), .any_wake_d(any_wake_d), .idle_i(idle_i),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    intc_rd_mux #(.N_SRC(N_SRC)) u_rd (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .pend_q(pend_q),
        .ena_q(ena_q), .cls_q(cls_q), .any_wake_q(any_wake_q),
        .prio_q(prio_q), .bus_rdata(bus_rdata)
    );

    // R5: fast line agrees with the registered request, enable and class state
    a_r5_fast_line: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (|(pend_q & ena_q & cls_q)));

    // R6: normal line agrees with the registered state for class-0 sources
    a_r6_normal_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(pend_q & ena_q & ~cls_q)));
endmodule

// File: tb/intc_two_class_tb.sv
module intc_two_class_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 40;

    localparam logic [7:0] O_NRM_LO = 8'h00, O_ENA_LO = 8'h04, O_CLS_LO = 8'h08;
    localparam logic [7:0] O_FST_LO = 8'h0C, O_RAW_LO = 8'h10, O_CTRL   = 8'h14;
    localparam logic [7:0] O_NRM_HI = 8'h9C, O_ENA_HI = 8'hA0, O_CLS_HI = 8'hA4;
    localparam logic [7:0] O_FST_HI = 8'hA8, O_RAW_HI = 8'hAC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic          idle_i = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o, fiq_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_two_class #(.N_SRC(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .idle_i(idle_i),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        src_i = 40'hFF_FFFF_FFFF;
        repeat (3) step();
        check("R10 irq in reset", {31'b0, irq_o}, 0);
        src_i = '0;
        rst_n = 1'b1;
        step();
        check("R10 outputs after reset", {29'b0, irq_o, fiq_o, wake_o}, 0);
        rd(O_ENA_LO, v); check("R10 enable low", v, 0);
        rd(O_CLS_HI, v); check("R10 class high", v, 0);
        rd(O_RAW_LO, v); check("R10 raw low", v, 0);
        rd(8'h1C, v);    check("R10 priority 0", v, 0);
        rd(O_CTRL, v);   check("R7 control reset reads 0", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        src_i = 40'h80_0000_0001;
        rd(O_RAW_LO, v); check("R1 raw low follows pin", v, 32'h1);
        rd(O_RAW_HI, v); check("R2 source 39 is high bit 7", v, 32'h80);
        src_i = '0;
        rd(O_RAW_LO, v); check("R1 fallen pin clears", v, 0);
    endtask

    task automatic t_views();
        logic [31:0] v;
        src_i = 40'hFF_0000_0F1F;
        wr(O_ENA_LO, 32'hFFFF_00FF);
        wr(O_CLS_LO, 32'h0000_000F);
        wr(O_ENA_HI, 32'hFFFF_FFFF);
        wr(O_CLS_HI, 32'h0000_000F);
        rd(O_RAW_LO, v); check("R4 raw ignores enable", v, 32'h0F1F);
        rd(O_NRM_LO, v); check("R4 normal view low", v, 32'h10);
        rd(O_FST_LO, v); check("R4 fast view low", v, 32'h0F);
        rd(O_ENA_HI, v); check("R2 high enable width", v, 32'hFF);
        rd(O_NRM_HI, v); check("R4 normal view high", v, 32'hF0);
        rd(O_FST_HI, v); check("R3 fast view high", v, 32'h0F);
        check("R5 fast line with both classes", {31'b0, fiq_o}, 1);
        check("R6 normal line with both classes", {31'b0, irq_o}, 1);
    endtask

    task automatic t_lines();
        wr(O_ENA_LO, 0);
        wr(O_ENA_HI, 0);
        check("R5 no enabled source", {30'b0, irq_o, fiq_o}, 0);
        src_i = 40'h10_0000_0008;
        wr(O_ENA_LO, 32'h8);
        check("R5 fast line raised", {31'b0, fiq_o}, 1);
        check("R6 normal line stays low", {31'b0, irq_o}, 0);
        wr(O_ENA_HI, 32'h10);
        check("R6 high bank normal source", {31'b0, irq_o}, 1);
        src_i[3] = 1'b0;
        step();
        check("R12 fast line drops one edge after pin", {31'b0, fiq_o}, 0);
        wr(O_ENA_HI, 0);
    endtask

    task automatic t_wake();
        logic [31:0] v;
        wr(O_ENA_LO, 0);
        wr(O_ENA_HI, 0);
        src_i = 40'h00_0000_0020;
        idle_i = 1'b1;
        wr(O_CTRL, 0);
        check("R8 wake on any request", {31'b0, wake_o}, 1);
        rd(O_CTRL, v); check("R7 control reads 0", v, 0);
        wr(O_CTRL, 1);
        check("R8 masked request no wake", {31'b0, wake_o}, 0);
        rd(O_CTRL, v); check("R7 control reads 1", v, 1);
        wr(O_ENA_LO, 32'h20);
        check("R8 enabled request wakes", {31'b0, wake_o}, 1);
        idle_i = 1'b0;
        step();
        check("R8 no wake when not idle", {31'b0, wake_o}, 0);
        wr(O_ENA_LO, 0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'hB4, 32'h1234_5665);
        wr(8'hCC, 32'h8000_0027);
        rd(8'h28, v); check("R9 priority 3 keeps valid and id", v, 32'h8000_003F);
        rd(8'hB4, v); check("R9 priority 33 drops reserved", v, 32'h0000_0025);
        rd(8'hCC, v); check("R3 priority 39 offset", v, 32'h8000_0027);
        rd(8'h24, v); check("R9 priority 2 untouched", v, 0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        src_i = 40'h00_0000_0100;
        wr(O_ENA_LO, 32'h0000_0100);
        wr(O_RAW_LO, 32'hFFFF_FFFF);
        wr(O_NRM_LO, 32'hFFFF_FFFF);
        wr(8'h18,    32'hFFFF_FFFF);
        wr(8'hD0,    32'hFFFF_FFFF);
        wr(8'h05,    32'hFFFF_FFFF);
        rd(O_RAW_LO, v); check("R11 raw not writable", v, 32'h100);
        rd(O_ENA_LO, v); check("R11 enable untouched", v, 32'h100);
        rd(O_CTRL, v);   check("R11 control untouched", v, 1);
        rd(8'h18, v);    check("R11 unmapped reads zero", v, 0);
        rd(8'hD0, v);    check("R11 beyond map reads zero", v, 0);
        check("R11 normal line unchanged", {31'b0, irq_o}, 1);
    endtask

    initial begin
        t_reset();
        t_level();
        t_views();
        t_lines();
        t_wake();
        t_prio();
        t_ignored();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule